// File: doc/BRIEF.md
# Scalar Shift-Right-by-Immediate Execution Unit

This unit executes one class of 64-bit scalar instructions: shift right by an immediate amount, with optional rounding, optional accumulation into the old destination value, and a bit-field insert form. Each cycle the issue logic can present a 32-bit instruction word together with the source operand and the current destination value, and raise `in_valid`. The unit decodes the word, checks that it is a legal member of the class, and computes the result. One clock later it returns the result, a write-enable for the register file, and an illegal-encoding flag.

The signed and unsigned forms, the rounding and accumulating variants and the insert form share one datapath. The datapath is wide enough that a shift of 64 and the rounding carry need no special cases, except for the insert form. Register file access and operand fetch are handled outside the unit. Bits 9:5 and 4:0 of the word carry register numbers that the unit does not use.

Top module: `scalar_shri_unit`

## Requirements
- R1: An instruction is legal only if bits 31:30 are 01, bits 28:23 are 111110 and bit 10 is 1. Any other value of these fields is flagged illegal.
- R2: Bit 22 is the top bit of the size/immediate field. If bit 22 is 0, the instruction is illegal.
- R3: The opcode is in bits 15:11, and bit 29 is the unsigned flag U. The legal opcodes are:
  - 00000: shift
  - 00010: shift and accumulate
  - 00100: rounding shift
  - 00110: rounding shift and accumulate
  - 01000: insert, legal only when U=1

  Insert with U=0, and every other opcode, is illegal.
- R4: The shift amount is 128 minus the 7-bit value in bits 22:16, which gives a range of 1 to 64.
- R5: A plain shift is arithmetic when U=0 and logical when U=1. A shift of 64 gives all copies of the sign bit when U=0, and 0 when U=1.
- R6: A rounding shift adds 2^(shift-1) before shifting, with no loss of the carry. A shift of 64 gives source bit 63 when U=1, and 0 when U=0.
- R7: An accumulating form adds the shifted (and, for the rounding form, rounded) value to the old destination, modulo 2^64.
- R8: Insert does the following:
  - It shifts the source right logically.
  - The low (64 - shift) bits of the shifted source replace the same bits of the old destination.
  - The top shift bits of the old destination are kept.
  - With a shift of 64 the result equals the old destination.
- R9: Timing and outputs:
  - `out_valid`, `wr_en`, `illegal` and `result` appear exactly one clock after `in_valid`.
  - `wr_en` and `illegal` are never both high.
  - An illegal instruction returns a result of 0.
  - A cycle without `in_valid` gives `out_valid`, `wr_en` and `illegal` low, and leaves `result` unchanged.
- R10: A synchronous active-high reset clears `out_valid`, `wr_en`, `illegal` and `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present |
| insn | input | 32 | Instruction word |
| src_op | input | 64 | Source operand |
| old_dst | input | 64 | Current destination value |
| out_valid | output | 1 | Registered copy of `in_valid` |
| wr_en | output | 1 | Legal instruction completed; write `result` |
| illegal | output | 1 | Instruction was not a legal encoding |
| result | output | 64 | Computed destination value |

## Verification
Most faults show up at the ports one cycle after the instruction that exposes them, because the unit holds no state beyond the output register.
- A wrong decode shows as a swapped `wr_en` and `illegal` pair.
- A datapath that is too narrow loses the rounding carry or the sign at a shift of 64, and so shows up only on the 64-bit-shift and near-overflow vectors.
- An insert mask that is off by one corrupts exactly the boundary bit between the kept and the replaced field.

The vectors are chosen to hit each of these boundaries.

// File: rtl/scalar_shri_unit.sv
module scalar_shri_unit #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [31:0]   insn,
  input  logic [DW-1:0] src_op,
  input  logic [DW-1:0] old_dst,
  output logic          out_valid,
  output logic          wr_en,
  output logic          illegal,
  output logic [DW-1:0] result
);
  localparam int XW = DW + 2;

  logic [4:0] op;
  logic       u;
  logic [7:0] sh;
  logic       fixed_ok, op_ok, legal;
  logic       is_rnd, is_acc, is_ins;

  assign op = insn[15:11];
  assign u  = insn[29];
  assign sh = 8'd128 - {1'b0, insn[22:16]};

  assign fixed_ok = (insn[31:30] == 2'b01) && (insn[28:23] == 6'b111110) && insn[10];
  assign op_ok    = (op == 5'd0) || (op == 5'd2) || (op == 5'd4) || (op == 5'd6)
                    || ((op == 5'd8) && u);
  assign legal    = fixed_ok && insn[22] && op_ok;

  assign is_rnd = (op == 5'd4) || (op == 5'd6);
  assign is_acc = (op == 5'd2) || (op == 5'd6);
  assign is_ins = (op == 5'd8);

  logic signed [XW-1:0] ext, rnd_add, sum;
  logic [DW-1:0] shr_val, ins_mask, ins_val, res;

  assign ext     = u ? $signed({2'b00, src_op}) : $signed({{2{src_op[DW-1]}}, src_op});
  assign rnd_add = is_rnd ? $signed(XW'(1) << (sh - 8'd1)) : '0;
  assign sum     = ext + rnd_add;
  assign shr_val = DW'(sum >>> sh);

  assign ins_mask = (sh >= 8'(DW)) ? '0 : ({DW{1'b1}} >> sh);
  assign ins_val  = (old_dst & ~ins_mask) | ((src_op >> sh) & ins_mask);

  assign res = is_ins ? ins_val : (is_acc ? old_dst + shr_val : shr_val);

  logic unused_fields;
  assign unused_fields = ^insn[9:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      illegal   <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && legal;
      illegal   <= in_valid && !legal;
      if (in_valid) result <= legal ? res : '0;
    end
  end

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid && (wr_en != illegal));
  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !wr_en && !illegal && $stable(result));
  // R9
  excl_chk: assert property (@(posedge clk) disable iff (rst) !(wr_en && illegal));
  // R1
  fixed_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !insn[10]) |=> illegal && !wr_en);
  // R2
  immh_top_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !insn[22]) |=> illegal && !wr_en && result == '0);
  // R3
  insert_signed_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn[15:11] == 5'd8 && !insn[29]) |=> illegal);
  // R8
  insert64_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn[31:16] == 16'h7F40 && insn[15:10] == 6'b010001)
      |=> wr_en && result == $past(old_dst));
  // R5
  ushr64_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn[31:16] == 16'h7F40 && insn[15:10] == 6'b000001)
      |=> wr_en && result == '0);
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !out_valid && !wr_en && !illegal && result == '0);
endmodule

// File: tb/scalar_shri_unit_tb.sv
module scalar_shri_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 25;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] src_op = '0, old_dst = '0;
  logic        out_valid, wr_en, illegal;
  logic [63:0] result;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scalar_shri_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn),
    .src_op(src_op), .old_dst(old_dst), .out_valid(out_valid),
    .wr_en(wr_en), .illegal(illegal), .result(result)
  );

  typedef struct packed {
    logic        u;
    logic [4:0]  op;
    logic [6:0]  imm;
    logic [63:0] src;
    logic [63:0] dst;
    logic [63:0] exp;
    logic        ill;
    logic [7:0]  req;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [63:0] MSB  = 64'h8000_0000_0000_0000;

  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd0, 7'd124, 64'hF000_0000_0000_0010, 64'd0, 64'h0F00_0000_0000_0001, 1'b0, 8'd5}, // R5
    '{1'b0, 5'd0, 7'd124, 64'hF000_0000_0000_0010, 64'd0, 64'hFF00_0000_0000_0001, 1'b0, 8'd5}, // R5
    '{1'b1, 5'd0, 7'd64,  ONES, 64'd0, 64'd0, 1'b0, 8'd5},                                      // R5
    '{1'b0, 5'd0, 7'd64,  MSB,  64'd0, ONES,  1'b0, 8'd5},                                      // R5
    '{1'b0, 5'd0, 7'd64,  64'h7FFF_FFFF_FFFF_FFFF, 64'd0, 64'd0, 1'b0, 8'd5},                   // R5
    '{1'b1, 5'd0, 7'd65,  MSB,  64'd0, 64'd1, 1'b0, 8'd4},                                      // R4
    '{1'b1, 5'd0, 7'd127, 64'd6, 64'd0, 64'd3, 1'b0, 8'd4},                                     // R4
    '{1'b1, 5'd4, 7'd127, 64'd3, 64'd0, 64'd2, 1'b0, 8'd6},                                     // R6
    '{1'b1, 5'd4, 7'd64,  MSB,  64'd0, 64'd1, 1'b0, 8'd6},                                      // R6
    '{1'b1, 5'd4, 7'd64,  ONES, 64'd0, 64'd1, 1'b0, 8'd6},                                      // R6
    '{1'b0, 5'd4, 7'd64,  MSB,  64'd0, 64'd0, 1'b0, 8'd6},                                      // R6
    '{1'b0, 5'd4, 7'd126, 64'hFFFF_FFFF_FFFF_FFFA, 64'd0, ONES, 1'b0, 8'd6},                    // R6
    '{1'b0, 5'd4, 7'd126, 64'hFFFF_FFFF_FFFF_FFF9, 64'd0, 64'hFFFF_FFFF_FFFF_FFFE, 1'b0, 8'd6}, // R6
    '{1'b1, 5'd2, 7'd120, 64'h100, 64'd5, 64'd6, 1'b0, 8'd7},                                   // R7
    '{1'b1, 5'd2, 7'd127, ONES, MSB, ONES, 1'b0, 8'd7},                                         // R7
    '{1'b0, 5'd2, 7'd124, 64'hFFFF_FFFF_FFFF_FFF0, 64'd1, 64'd0, 1'b0, 8'd7},                   // R7
    '{1'b1, 5'd2, 7'd127, 64'd2, ONES, 64'd0, 1'b0, 8'd7},                                      // R7 wrap
    '{1'b1, 5'd6, 7'd124, 64'h18, 64'h10, 64'h12, 1'b0, 8'd7},                                  // R7
    '{1'b0, 5'd6, 7'd64,  ONES, 64'd7, 64'd7, 1'b0, 8'd7},                                      // R7
    '{1'b1, 5'd8, 7'd120, 64'h1122_3344_5566_7788, 64'hAABB_CCDD_EEFF_0011,
                          64'hAA11_2233_4455_6677, 1'b0, 8'd8},                                 // R8
    '{1'b1, 5'd8, 7'd64,  ONES, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1'b0, 8'd8},  // R8
    '{1'b1, 5'd8, 7'd127, ONES, 64'd0, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 8'd8},                    // R8
    '{1'b0, 5'd8, 7'd120, ONES, ONES, 64'd0, 1'b1, 8'd3},                                       // R3
    '{1'b1, 5'd10, 7'd120, ONES, ONES, 64'd0, 1'b1, 8'd3},                                      // R3
    '{1'b1, 5'd0, 7'd63,  ONES, ONES, 64'd0, 1'b1, 8'd2}                                        // R2
  };

  function automatic logic [31:0] mk(input logic u, input logic [4:0] op, input logic [6:0] imm);
    return {2'b01, u, 6'b111110, imm, op, 1'b1, 5'd3, 5'd4};
  endfunction

  task automatic chk(input string tag, input logic ok, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] s, input logic [63:0] d);
    @(negedge clk);
    insn = w; src_op = s; old_dst = d; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset", !out_valid && !wr_en && !illegal && result == '0,
        {61'd0, out_valid, wr_en, illegal}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      issue(mk(VECS[i].u, VECS[i].op, VECS[i].imm), VECS[i].src, VECS[i].dst);
      chk($sformatf("R%0d vec %0d result", VECS[i].req, i), result == VECS[i].exp, result, VECS[i].exp);
      chk($sformatf("R9 vec %0d flags", i),
          out_valid && (illegal == VECS[i].ill) && (wr_en == !VECS[i].ill),
          {61'd0, out_valid, wr_en, illegal}, {61'd0, 1'b1, !VECS[i].ill, VECS[i].ill});
    end

    // R1 fixed fields corrupted
    issue(mk(1'b1, 5'd0, 7'd124) & ~32'h400, ONES, 64'd0);
    chk("R1 bit10 clear", illegal && !wr_en, {63'd0, illegal}, 64'd1);
    issue(mk(1'b1, 5'd0, 7'd124) | 32'h8000_0000, ONES, 64'd0);
    chk("R1 bits31:30", illegal && !wr_en, {63'd0, illegal}, 64'd1);
    issue(mk(1'b1, 5'd0, 7'd124) ^ 32'h0080_0000, ONES, 64'd0);
    chk("R1 bits28:23", illegal && !wr_en, {63'd0, illegal}, 64'd1);

    // R9 idle cycle holds result
    issue(mk(1'b1, 5'd0, 7'd124), 64'h50, 64'd0);
    @(negedge clk);
    chk("R9 idle flags", !out_valid && !wr_en && !illegal,
        {61'd0, out_valid, wr_en, illegal}, 64'd0);
    chk("R9 idle hold", result == 64'h5, result, 64'h5);

    // R10 reset mid-stream
    @(negedge clk);
    insn = mk(1'b1, 5'd0, 7'd127); src_op = 64'd8; in_valid = 1'b1; rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    chk("R10 reset wins", !out_valid && !wr_en && result == '0, result, 64'd0);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule